// File: doc/BRIEF.md
# Registered Command Buffer with Delayed-Parity Check

This block sits between a memory controller and a module's memory devices and re-times the address and command lines. On every rising clock edge it registers a wide command word and a small group of control lines (clock-enable and termination lines), and drives the registered copies to its outputs one edge later. A parity bit covering the command word arrives one clock after the word itself; the block holds the word for one extra stage, compares it against that late bit, and pulls an active-low error flag that stays latched for a fixed number of edges after the last bad word.

Chip-select inputs decide whether the command word is refreshed. When the gate-enable input is high and no chip select is active, the command outputs keep their previous value; the control lines and the registered chip selects update on every edge regardless. An asynchronous active-low reset forces all registered outputs low and clears the error flag, and for a short wake-up window after reset is released the block ignores its inputs so that no stray value reaches the outputs. The timing is fixed, so the interfaces are plain pins with no valid/ready handshake and no back-pressure.

Top module: `cmd_reg_buf`

## Requirements
- R1: While `rst_n` is low, `cmd_q`, `ctl_q` and `cs_n_q` are all zero and `err_n` is 1; this takes effect at once, without waiting for a clock edge.
- R2: For the first WAKE_CYC (default 2) rising edges after `rst_n` goes high the inputs are ignored: `cmd_q`, `ctl_q`, `cs_n_q` stay zero and `err_n` stays 1.
- R3: On an enabled edge where the command word is loaded, `cmd_q` shows the `cmd_in` value sampled at that edge (one edge of latency).
- R4: On every enabled edge `ctl_q` and `cs_n_q` take `ctl_in` and `cs_n_in`, whatever the chip-select and gate-enable state.
- R5: When `cs_gate_en` is 1 and every bit of `cs_n_in` is 1 (no chip select active; chip selects are active low), `cmd_q` keeps its previous value.
- R6: When `cs_gate_en` is 0, `cmd_q` loads `cmd_in` even with no chip select active.
- R7: Parity is odd: the `par_in` value sampled at the edge after a word was loaded covers that word, and a mismatch (XOR of all word bits and `par_in` equal to 0) drives `err_n` to 0 at that later edge.
- R8: After the last mismatching edge `err_n` remains 0 for ERR_HOLD (default 2) further edges and returns to 1 on the edge after that; consecutive mismatches extend the low period.
- R9: A word that was not loaded (suspended by R5, or arriving during the R2 window) is not checked, so a wrong `par_in` in the following cycle leaves `err_n` at 1.
- R10: Driving `rst_n` low while `err_n` is 0 returns `err_n` to 1 immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | DATA_W | Command/address word, parity-protected |
| ctl_in | input | CTL_W | Clock-enable and termination lines, never suspended |
| cs_n_in | input | NCS | Active-low chip selects |
| cs_gate_en | input | 1 | 1: suspend command word when no chip select is active |
| par_in | input | 1 | Odd parity for the word loaded one edge earlier |
| cmd_q | output | DATA_W | Registered command word |
| ctl_q | output | CTL_W | Registered control lines |
| cs_n_q | output | NCS | Registered chip selects |
| err_n | output | 1 | Latched active-low parity error flag |

## Verification
Data results are due one rising edge after the inputs are applied, while the error flag is due two edges after its word (one for the word, one for the late parity bit) and then stays low for exactly ERR_HOLD more edges. The bench drives every input on the falling edge and samples one nanosecond after the next rising edge, so each check reads the state produced by exactly one edge; the parity checks count edges from the bad bit and test low, low, low, high. The wake-up window is checked edge by edge after reset release, and reset effects are sampled mid-cycle to show they need no clock.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  // Decision made each edge for the command word register.
  typedef enum logic {
    CAP_HOLD = 1'b0,
    CAP_LOAD = 1'b1
  } cap_e;
endpackage

// File: rtl/cmdbuf_wake.sv
// Counts edges after reset release; inputs are accepted only once done.
module cmdbuf_wake #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic en
);
  localparam int CW = $clog2(WAKE_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else if (cnt_r != LIMIT) cnt_r <= cnt_r + 1'b1;
  end

  assign en = (cnt_r == LIMIT);
endmodule

// File: rtl/cmdbuf_gate.sv
// Decides whether the command word is loaded this edge.
module cmdbuf_gate
  import cmdbuf_pkg::*;
#(
  parameter int NCS = 2
) (
  input  logic           en,
  input  logic [NCS-1:0] cs_n_in,
  input  logic           cs_gate_en,
  output cap_e           cap
);
  logic none_sel;
  assign none_sel = &cs_n_in;

  always_comb begin
    cap = CAP_HOLD;
    if (en && !(cs_gate_en && none_sel)) cap = CAP_LOAD;
  end
endmodule

// File: rtl/cmdbuf_parchk.sv
// Holds the loaded word one extra stage, checks it against the late parity
// bit, and stretches the active-low error flag.
module cmdbuf_parchk #(
  parameter int DATA_W   = 22,
  parameter int ERR_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] cmd_in,
  input  logic              par_in,
  output logic              err_n
);
  localparam int HW = $clog2(ERR_HOLD + 2);
  localparam logic [HW-1:0] HOLD_INIT = HW'(ERR_HOLD);

  logic [DATA_W-1:0] word_r;
  logic              vld_r;
  logic [HW-1:0]     hold_r;
  logic              err_n_r;
  logic              bad;

  // odd parity: word bits plus parity must XOR to 1
  assign bad = vld_r && ((^word_r ^ par_in) == 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_r  <= '0;
      vld_r   <= 1'b0;
      hold_r  <= '0;
      err_n_r <= 1'b1;
    end else begin
      vld_r <= load;
      if (load) word_r <= cmd_in;
      if (bad) begin
        err_n_r <= 1'b0;
        hold_r  <= HOLD_INIT;
      end else if (hold_r != '0) begin
        hold_r <= hold_r - 1'b1;
      end else begin
        err_n_r <= 1'b1;
      end
    end
  end

  assign err_n = err_n_r;
endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf
  import cmdbuf_pkg::*;
#(
  parameter int DATA_W   = 22,
  parameter int CTL_W    = 4,
  parameter int NCS      = 2,
  parameter int WAKE_CYC = 2,
  parameter int ERR_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cmd_in,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic [NCS-1:0]    cs_n_in,
  input  logic              cs_gate_en,
  input  logic              par_in,
  output logic [DATA_W-1:0] cmd_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [NCS-1:0]    cs_n_q,
  output logic              err_n
);
  logic en_w;
  cap_e cap_w;
  logic load_w;

  cmdbuf_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en_w)
  );

  cmdbuf_gate #(.NCS(NCS)) u_gate (
    .en        (en_w),
    .cs_n_in   (cs_n_in),
    .cs_gate_en(cs_gate_en),
    .cap       (cap_w)
  );

  assign load_w = (cap_w == CAP_LOAD);

  cmdbuf_parchk #(.DATA_W(DATA_W), .ERR_HOLD(ERR_HOLD)) u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_w),
    .cmd_in(cmd_in),
    .par_in(par_in),
    .err_n (err_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ctl_q  <= '0;
      cs_n_q <= '0;
    end else begin
      if (load_w) cmd_q <= cmd_in;
      if (en_w) begin
        ctl_q  <= ctl_in;
        cs_n_q <= cs_n_in;
      end
    end
  end
endmodule

// File: rtl/cmd_reg_buf_chk.sv
module cmd_reg_buf_chk #(
  parameter int DATA_W = 22,
  parameter int CTL_W  = 4,
  parameter int NCS    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [DATA_W-1:0] cmd_in,
  input logic [CTL_W-1:0]  ctl_in,
  input logic [NCS-1:0]    cs_n_in,
  input logic              cs_gate_en,
  input logic [DATA_W-1:0] cmd_q,
  input logic [CTL_W-1:0]  ctl_q,
  input logic              err_n
);
  assert_wake_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cmd_q == '0 && ctl_q == '0 && err_n));

  assert_load_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(cs_gate_en && (&cs_n_in))) |=> cmd_q == $past(cmd_in));

  assert_ctl_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ctl_q == $past(ctl_in));

  assert_cmd_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cs_gate_en && (&cs_n_in)) |=> $stable(cmd_q));

  assert_err_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n);
endmodule

bind cmd_reg_buf cmd_reg_buf_chk #(.DATA_W(DATA_W), .CTL_W(CTL_W), .NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en_w),
  .cmd_in    (cmd_in),
  .ctl_in    (ctl_in),
  .cs_n_in   (cs_n_in),
  .cs_gate_en(cs_gate_en),
  .cmd_q     (cmd_q),
  .ctl_q     (ctl_q),
  .err_n     (err_n)
);

// File: tb/cmd_reg_buf_bench.sv
`timescale 1ns/1ps
module cmd_reg_buf_bench;
  localparam int DATA_W = 22;
  localparam int CTL_W  = 4;
  localparam int NCS    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] cmd_in = '0;
  logic [CTL_W-1:0]  ctl_in = '0;
  logic [NCS-1:0]    cs_n_in = '1;
  logic              cs_gate_en = 1'b1;
  logic              par_in = 1'b0;
  logic [DATA_W-1:0] cmd_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [NCS-1:0]    cs_n_q;
  logic              err_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] prev_cmd = '0;

  always #2 clk = ~clk;

  cmd_reg_buf #(.DATA_W(DATA_W), .CTL_W(CTL_W), .NCS(NCS)) u_cmd_reg_buf (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .ctl_in(ctl_in),
    .cs_n_in(cs_n_in), .cs_gate_en(cs_gate_en), .par_in(par_in),
    .cmd_q(cmd_q), .ctl_q(ctl_q), .cs_n_q(cs_n_q), .err_n(err_n)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge; par_in covers the previous word
  task automatic step(input logic [DATA_W-1:0] c, input logic [CTL_W-1:0] t,
                      input logic [NCS-1:0] cs, input logic g, input bit corrupt);
    @(negedge clk);
    par_in     = (~^prev_cmd) ^ corrupt;
    cmd_in     = c;
    ctl_in     = t;
    cs_n_in    = cs;
    cs_gate_en = g;
    prev_cmd   = c;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    step(22'h3ABCDE, 4'hF, 2'b00, 1'b0, 1'b0);
    check(cmd_q == '0 && ctl_q == '0 && cs_n_q == '0, "R1 outputs zero in reset",
          {cmd_q, ctl_q, cs_n_q}, 64'h0);
    check(err_n == 1'b1, "R1 err_n high in reset", err_n, 1);
  endtask

  task automatic t_wake_r2();
    @(negedge clk) rst_n = 1'b1;
    step(22'h155555, 4'h9, 2'b10, 1'b1, 1'b1);
    check(cmd_q == '0 && ctl_q == '0, "R2 ignored during wake", {cmd_q, ctl_q}, 0);
    check(err_n == 1'b1, "R2 no error during wake", err_n, 1);
    step(22'h155555, 4'h9, 2'b10, 1'b1, 1'b0);
    check(cmd_q == 22'h155555, "R3 first load after wake", cmd_q, 22'h155555);
  endtask

  task automatic t_pass_r3();
    step(22'h0F0F0F, 4'h3, 2'b01, 1'b1, 1'b0);
    check(cmd_q == 22'h0F0F0F, "R3 load with cs active", cmd_q, 22'h0F0F0F);
    step(22'h2A1234, 4'h5, 2'b00, 1'b1, 1'b0);
    check(cmd_q == 22'h2A1234, "R3 load both cs active", cmd_q, 22'h2A1234);
    check(err_n == 1'b1, "R7 good parity no error", err_n, 1);
  endtask

  task automatic t_gate_r5_r6();
    step(22'h111111, 4'hA, 2'b11, 1'b1, 1'b0);
    check(cmd_q == 22'h2A1234, "R5 suspended holds", cmd_q, 22'h2A1234);
    check(ctl_q == 4'hA, "R4 ctl updates while suspended", ctl_q, 4'hA);
    check(cs_n_q == 2'b11, "R4 cs_n_q updates while suspended", cs_n_q, 2'b11);
    // parity for the suspended word is wrong: must be ignored
    step(22'h222222, 4'h6, 2'b11, 1'b0, 1'b1);
    check(cmd_q == 22'h222222, "R6 gate disabled loads", cmd_q, 22'h222222);
    check(err_n == 1'b1, "R9 unloaded word not checked", err_n, 1);
    step(22'h000001, 4'h0, 2'b10, 1'b1, 1'b0);
    check(err_n == 1'b1, "R7 good parity after gate test", err_n, 1);
  endtask

  task automatic t_err_single_r7_r8();
    step(22'h3C3C3C, 4'h1, 2'b10, 1'b1, 1'b0);
    step(22'h0000AA, 4'h1, 2'b10, 1'b1, 1'b1);
    check(err_n == 1'b0, "R7 mismatch flags error", err_n, 0);
    step(22'h000055, 4'h1, 2'b10, 1'b1, 1'b0);
    check(err_n == 1'b0, "R8 held edge 1", err_n, 0);
    step(22'h000077, 4'h1, 2'b10, 1'b1, 1'b0);
    check(err_n == 1'b0, "R8 held edge 2", err_n, 0);
    step(22'h000099, 4'h1, 2'b10, 1'b1, 1'b0);
    check(err_n == 1'b1, "R8 released after hold", err_n, 1);
  endtask

  task automatic t_err_burst_r8();
    step(22'h012345, 4'h2, 2'b01, 1'b1, 1'b1);
    step(22'h054321, 4'h2, 2'b01, 1'b1, 1'b1);
    check(err_n == 1'b0, "R8 burst low", err_n, 0);
    step(22'h0ABCDE, 4'h2, 2'b01, 1'b1, 1'b0);
    check(err_n == 1'b0, "R8 burst hold 1", err_n, 0);
    step(22'h0EDCBA, 4'h2, 2'b01, 1'b1, 1'b0);
    check(err_n == 1'b0, "R8 burst hold 2", err_n, 0);
    step(22'h000000, 4'h2, 2'b01, 1'b1, 1'b0);
    check(err_n == 1'b1, "R8 burst released", err_n, 1);
  endtask

  task automatic t_reset_clear_r10();
    step(22'h3FFFFF, 4'h7, 2'b10, 1'b1, 1'b1);
    check(err_n == 1'b0, "R7 error before reset", err_n, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check(err_n == 1'b1, "R10 reset clears error", err_n, 1);
    check(cmd_q == '0 && ctl_q == '0 && cs_n_q == '0, "R1 async clear mid-cycle",
          {cmd_q, ctl_q, cs_n_q}, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_wake_r2();
    t_pass_r3();
    t_gate_r5_r6();
    t_err_single_r7_r8();
    t_err_burst_r8();
    t_reset_clear_r10();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule